// File: doc/BRIEF.md
# Tagged Reservation Station Cluster

This block holds the waiting floating-point operations of a dynamically scheduled core. It also keeps a status table that renames each architectural register to the station that will produce it. Instructions arrive one at a time and in program order. Each one goes into the lowest-numbered free station of its unit type, either the adder or the multiply/divide unit. Each source operand is stored either as a value or as the tag of the producing station. The destination register's status entry is then set to the new station's tag.

A single tagged result bus does two jobs. It wakes up waiting stations: every station whose pending operand tag equals the broadcast tag captures the data. It also retires register status: every register whose status equals the tag takes the data and goes back to "no producer". A station is dispatched to its unit once both operands hold values. Among the ready stations of one unit, the lowest-numbered one goes first. A station is released only when its own result appears on the bus.

Each station runs a four-state machine:
- `ST_IDLE` (free) moves on *load* to `ST_READY` if both operands arrive as values, otherwise to `ST_WAIT`.
- `ST_WAIT` moves on *wakeup* to `ST_READY` once every pending tag has been matched on the bus.
- `ST_READY` moves on *grant* to `ST_EXEC` when it is dispatched.
- `ST_EXEC` moves on *release* to `ST_IDLE` when the bus carries its own tag.

Top module: `rs_cluster`

## Requirements
- R1: After reset all stations are free, no dispatch is offered, and every register reads value 0 with status tag 0.
- R2: `iss_ready` is high exactly when a station of the unit chosen by `iss_unit` is free (`iss_unit` 0 selects the adder, 1 the multiply/divide unit). An issue with `iss_ready` low changes nothing. An accepted issue takes the lowest-numbered free station of that unit. Adder stations carry tags 1 to N_ADD and multiply/divide stations carry tags N_ADD+1 to N_ADD+N_MUL. Tag 0 means "no producer".
- R3: On an accepted issue, the status of `iss_dst` becomes the tag of the chosen station from the next cycle on.
- R4: A source whose register status is 0 is captured as that register's value. A source with a nonzero status is captured as that tag.
- R5: If the bus broadcasts, in the issue cycle, the tag that a source register is waiting for, the station captures the bus data for that source instead of the tag.
- R6: A waiting station whose pending tag equals a valid, nonzero bus tag captures the data and clears that tag. A bus cycle with `bc_valid` low or tag 0 has no effect.
- R7: A station is offered for dispatch only while both operands hold values. It is offered from the cycle after its last operand arrives, and it is dispatched only once.
- R8: When several stations of one unit are ready, the lowest-numbered one is dispatched, and at most one per unit per cycle.
- R9: A dispatched station becomes free in the cycle after the bus broadcasts its own tag.
- R10: A broadcast updates the value of every register whose status equals the tag and clears that status. Other registers are unchanged.
- R11: If an accepted issue targets a register whose status equals the tag broadcast in the same cycle, the new tag wins and the register value is left unchanged.
- R12: The operation code and the immediate field given at issue appear unchanged on the dispatch outputs of that station.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered at the head of the queue |
| iss_unit | input | 1 | Unit type: 0 adder, 1 multiply/divide |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | log2(N_REG) | Destination register |
| iss_srcj | input | log2(N_REG) | First source register |
| iss_srck | input | log2(N_REG) | Second source register |
| iss_imm | input | IMM_W | Address/immediate field |
| iss_ready | output | 1 | A station of the selected type is free |
| bc_valid | input | 1 | Result bus carries a result |
| bc_tag | input | TAG_W | Producing station tag |
| bc_data | input | DATA_W | Result value |
| add_go | output | 1 | Adder dispatch this cycle |
| add_tag | output | TAG_W | Tag of dispatched adder station |
| add_op | output | OP_W | Operation code to adder |
| add_a | output | DATA_W | First operand to adder |
| add_b | output | DATA_W | Second operand to adder |
| add_imm | output | IMM_W | Immediate to adder |
| mul_go | output | 1 | Multiply/divide dispatch this cycle |
| mul_tag | output | TAG_W | Tag of dispatched multiply station |
| mul_op | output | OP_W | Operation code to multiply unit |
| mul_a | output | DATA_W | First operand to multiply unit |
| mul_b | output | DATA_W | Second operand to multiply unit |
| mul_imm | output | IMM_W | Immediate to multiply unit |
| peek_reg | input | log2(N_REG) | Register selected for observation |
| peek_val | output | DATA_W | Value of the selected register |
| peek_tag | output | TAG_W | Status tag of the selected register |

## Verification
The assertions check several rules on every cycle:
- a ready station holds no pending tag;
- grants and loads only reach stations in the proper state;
- each unit dispatches at most one station;
- a matching broadcast clears a register's status and writes its value;
- a same-cycle issue overrides that clear.

The other behaviours only show up through the bench's scenarios, compared against a behavioural model on every cycle:
- the lowest-free allocation and the tag numbering;
- the bypass of a broadcast into an issuing instruction;
- wakeup chains across both units;
- ordering among several ready stations;
- release timing;
- a full unit refusing issue.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READY,
        ST_EXEC
    } rs_state_e;

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4,
    parameter int OP_W   = 4,
    parameter int IMM_W  = 16,
    parameter int MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OP_W-1:0]   ld_op,
    input  logic [DATA_W-1:0] ld_vj,
    input  logic [DATA_W-1:0] ld_vk,
    input  logic [TAG_W-1:0]  ld_qj,
    input  logic [TAG_W-1:0]  ld_qk,
    input  logic [IMM_W-1:0]  ld_imm,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    input  logic              grant,
    output logic              is_free,
    output logic              is_ready,
    output logic [OP_W-1:0]   out_op,
    output logic [DATA_W-1:0] out_vj,
    output logic [DATA_W-1:0] out_vk,
    output logic [IMM_W-1:0]  out_imm
);

    localparam logic [TAG_W-1:0] SELF = TAG_W'(MY_TAG);

    rs_state_e         state_q, state_d;
    logic [OP_W-1:0]   op_q;
    logic [DATA_W-1:0] vj_q, vk_q;
    logic [TAG_W-1:0]  qj_q, qk_q;
    logic [IMM_W-1:0]  imm_q;

    logic snoop_j, snoop_k, opj_ok, opk_ok, own_result;

    assign snoop_j    = bc_valid && (bc_tag != '0) && (qj_q == bc_tag);
    assign snoop_k    = bc_valid && (bc_tag != '0) && (qk_q == bc_tag);
    assign opj_ok     = (qj_q == '0) || snoop_j;
    assign opk_ok     = (qk_q == '0) || snoop_k;
    assign own_result = bc_valid && (bc_tag == SELF);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: load, wakeup, grant, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load)
                          state_d = ((ld_qj == '0) && (ld_qk == '0)) ? ST_READY : ST_WAIT;
            ST_WAIT:  if (opj_ok && opk_ok) state_d = ST_READY;
            ST_READY: if (grant)            state_d = ST_EXEC;
            ST_EXEC:  if (own_result)       state_d = ST_IDLE;
        endcase
    end

    // operand and instruction fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            vj_q  <= '0;
            vk_q  <= '0;
            qj_q  <= '0;
            qk_q  <= '0;
            imm_q <= '0;
        end else if (load) begin
            op_q  <= ld_op;
            vj_q  <= ld_vj;
            vk_q  <= ld_vk;
            qj_q  <= ld_qj;
            qk_q  <= ld_qk;
            imm_q <= ld_imm;
        end else begin
            if (snoop_j) begin
                vj_q <= bc_data;
                qj_q <= '0;
            end
            if (snoop_k) begin
                vk_q <= bc_data;
                qk_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        is_free  = (state_q == ST_IDLE);
        is_ready = (state_q == ST_READY);
        out_op   = op_q;
        out_vj   = vj_q;
        out_vk   = vk_q;
        out_imm  = imm_q;
    end

    // R7: a station waiting for dispatch holds no producer tag
    p_ready_has_ops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY) |-> ((qj_q == '0) && (qk_q == '0)));

    // R7: the dispatch picker grants only stations that are ready
    p_grant_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (state_q == ST_READY));

    // R2: the allocator loads only free stations
    p_load_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state_q == ST_IDLE));

endmodule

// File: rtl/rs_regstat.sv
module rs_regstat #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4,
    parameter int N_REG  = 8,
    parameter int RAW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [RAW-1:0]    set_reg,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    input  logic [RAW-1:0]    rdj_addr,
    input  logic [RAW-1:0]    rdk_addr,
    input  logic [RAW-1:0]    rdx_addr,
    output logic [DATA_W-1:0] rdj_val,
    output logic [TAG_W-1:0]  rdj_tag,
    output logic [DATA_W-1:0] rdk_val,
    output logic [TAG_W-1:0]  rdk_tag,
    output logic [DATA_W-1:0] rdx_val,
    output logic [TAG_W-1:0]  rdx_tag
);

    logic [DATA_W-1:0] val_q  [N_REG];
    logic [TAG_W-1:0]  stat_q [N_REG];

    always_ff @(posedge clk) begin
        for (int r = 0; r < N_REG; r++) begin
            if (!rst_n) begin
                val_q[r]  <= '0;
                stat_q[r] <= '0;
            end else if (set_en && (set_reg == RAW'(r))) begin
                stat_q[r] <= set_tag;
            end else if (bc_valid && (bc_tag != '0) && (stat_q[r] == bc_tag)) begin
                val_q[r]  <= bc_data;
                stat_q[r] <= '0;
            end
        end
    end

    always_comb begin
        rdj_val = val_q[rdj_addr];
        rdj_tag = stat_q[rdj_addr];
        rdk_val = val_q[rdk_addr];
        rdk_tag = stat_q[rdk_addr];
        rdx_val = val_q[rdx_addr];
        rdx_tag = stat_q[rdx_addr];
    end

    for (genvar r = 0; r < N_REG; r++) begin : g_chk
        // R10: a matching broadcast writes the value and clears the status
        p_clear_on_bcast_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && (bc_tag != '0) && (stat_q[r] == bc_tag) &&
             !(set_en && (set_reg == RAW'(r))))
            |=> ((stat_q[r] == '0) && (val_q[r] == $past(bc_data))));

        // R11: an issue to the register overrides a same-cycle clear
        p_issue_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en && (set_reg == RAW'(r)))
            |=> ((stat_q[r] == $past(set_tag)) && $stable(val_q[r])));
    end

endmodule

// File: rtl/rs_cluster.sv
module rs_cluster #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4,
    parameter int OP_W   = 4,
    parameter int IMM_W  = 16,
    parameter int N_ADD  = 3,
    parameter int N_MUL  = 2,
    parameter int N_REG  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      iss_valid,
    input  logic                      iss_unit,
    input  logic [OP_W-1:0]           iss_op,
    input  logic [$clog2(N_REG)-1:0]  iss_dst,
    input  logic [$clog2(N_REG)-1:0]  iss_srcj,
    input  logic [$clog2(N_REG)-1:0]  iss_srck,
    input  logic [IMM_W-1:0]          iss_imm,
    output logic                      iss_ready,
    input  logic                      bc_valid,
    input  logic [TAG_W-1:0]          bc_tag,
    input  logic [DATA_W-1:0]         bc_data,
    output logic                      add_go,
    output logic [TAG_W-1:0]          add_tag,
    output logic [OP_W-1:0]           add_op,
    output logic [DATA_W-1:0]         add_a,
    output logic [DATA_W-1:0]         add_b,
    output logic [IMM_W-1:0]          add_imm,
    output logic                      mul_go,
    output logic [TAG_W-1:0]          mul_tag,
    output logic [OP_W-1:0]           mul_op,
    output logic [DATA_W-1:0]         mul_a,
    output logic [DATA_W-1:0]         mul_b,
    output logic [IMM_W-1:0]          mul_imm,
    input  logic [$clog2(N_REG)-1:0]  peek_reg,
    output logic [DATA_W-1:0]         peek_val,
    output logic [TAG_W-1:0]          peek_tag
);

    localparam int N_RS = N_ADD + N_MUL;
    localparam int RAW  = $clog2(N_REG);
    localparam int AIW  = (N_ADD > 1) ? $clog2(N_ADD) : 1;
    localparam int MIW  = (N_MUL > 1) ? $clog2(N_MUL) : 1;

    logic [N_RS-1:0]   st_free, st_ready, st_load, disp_gnt;
    logic [OP_W-1:0]   st_op  [N_RS];
    logic [DATA_W-1:0] st_vj  [N_RS];
    logic [DATA_W-1:0] st_vk  [N_RS];
    logic [IMM_W-1:0]  st_imm [N_RS];

    // ---------------- allocation ----------------
    logic [N_ADD-1:0] alloc_add_gnt;
    logic [N_MUL-1:0] alloc_mul_gnt;
    logic [AIW-1:0]   alloc_add_idx;
    logic [MIW-1:0]   alloc_mul_idx;
    logic             add_has_free, mul_has_free, iss_fire;
    logic [TAG_W-1:0] alloc_tag;

    rs_pick #(.N(N_ADD), .IW(AIW)) u_alloc_add (
        .req(st_free[N_ADD-1:0]), .gnt(alloc_add_gnt),
        .idx(alloc_add_idx), .any(add_has_free)
    );

    rs_pick #(.N(N_MUL), .IW(MIW)) u_alloc_mul (
        .req(st_free[N_RS-1:N_ADD]), .gnt(alloc_mul_gnt),
        .idx(alloc_mul_idx), .any(mul_has_free)
    );

    always_comb begin
        iss_ready = iss_unit ? mul_has_free : add_has_free;
        iss_fire  = iss_valid && iss_ready;
        alloc_tag = iss_unit ? (TAG_W'(N_ADD + 1) + TAG_W'(alloc_mul_idx))
                             : (TAG_W'(1) + TAG_W'(alloc_add_idx));
        st_load   = '0;
        if (iss_fire) begin
            if (iss_unit) st_load[N_RS-1:N_ADD] = alloc_mul_gnt;
            else          st_load[N_ADD-1:0]    = alloc_add_gnt;
        end
    end

    // ---------------- register status and operand capture ----------------
    logic [DATA_W-1:0] rj_val, rk_val;
    logic [TAG_W-1:0]  rj_tag, rk_tag;
    logic [DATA_W-1:0] cap_vj, cap_vk;
    logic [TAG_W-1:0]  cap_qj, cap_qk;

    rs_regstat #(.DATA_W(DATA_W), .TAG_W(TAG_W), .N_REG(N_REG), .RAW(RAW)) u_regstat (
        .clk(clk), .rst_n(rst_n),
        .set_en(iss_fire), .set_reg(iss_dst), .set_tag(alloc_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .rdj_addr(iss_srcj), .rdk_addr(iss_srck), .rdx_addr(peek_reg),
        .rdj_val(rj_val), .rdj_tag(rj_tag),
        .rdk_val(rk_val), .rdk_tag(rk_tag),
        .rdx_val(peek_val), .rdx_tag(peek_tag)
    );

    always_comb begin
        if (rj_tag == '0) begin
            cap_vj = rj_val;  cap_qj = '0;
        end else if (bc_valid && (bc_tag == rj_tag)) begin
            cap_vj = bc_data; cap_qj = '0;
        end else begin
            cap_vj = '0;      cap_qj = rj_tag;
        end
        if (rk_tag == '0) begin
            cap_vk = rk_val;  cap_qk = '0;
        end else if (bc_valid && (bc_tag == rk_tag)) begin
            cap_vk = bc_data; cap_qk = '0;
        end else begin
            cap_vk = '0;      cap_qk = rk_tag;
        end
    end

    // ---------------- stations ----------------
    for (genvar s = 0; s < N_RS; s++) begin : g_st
        rs_station #(
            .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W),
            .IMM_W(IMM_W), .MY_TAG(s + 1)
        ) u_st (
            .clk(clk), .rst_n(rst_n),
            .load(st_load[s]),
            .ld_op(iss_op), .ld_vj(cap_vj), .ld_vk(cap_vk),
            .ld_qj(cap_qj), .ld_qk(cap_qk), .ld_imm(iss_imm),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
            .grant(disp_gnt[s]),
            .is_free(st_free[s]), .is_ready(st_ready[s]),
            .out_op(st_op[s]), .out_vj(st_vj[s]),
            .out_vk(st_vk[s]), .out_imm(st_imm[s])
        );
    end

    // ---------------- dispatch ----------------
    logic [N_ADD-1:0] d_add_gnt;
    logic [N_MUL-1:0] d_mul_gnt;
    logic [AIW-1:0]   d_add_idx;
    logic [MIW-1:0]   d_mul_idx;

    rs_pick #(.N(N_ADD), .IW(AIW)) u_disp_add (
        .req(st_ready[N_ADD-1:0]), .gnt(d_add_gnt),
        .idx(d_add_idx), .any(add_go)
    );

    rs_pick #(.N(N_MUL), .IW(MIW)) u_disp_mul (
        .req(st_ready[N_RS-1:N_ADD]), .gnt(d_mul_gnt),
        .idx(d_mul_idx), .any(mul_go)
    );

    assign disp_gnt = {d_mul_gnt, d_add_gnt};

    always_comb begin
        add_tag = TAG_W'(1) + TAG_W'(d_add_idx);
        add_op  = '0; add_a = '0; add_b = '0; add_imm = '0;
        for (int i = 0; i < N_ADD; i++) begin
            if (d_add_gnt[i]) begin
                add_op  = st_op[i];
                add_a   = st_vj[i];
                add_b   = st_vk[i];
                add_imm = st_imm[i];
            end
        end
        mul_tag = TAG_W'(N_ADD + 1) + TAG_W'(d_mul_idx);
        mul_op  = '0; mul_a = '0; mul_b = '0; mul_imm = '0;
        for (int i = 0; i < N_MUL; i++) begin
            if (d_mul_gnt[i]) begin
                mul_op  = st_op[N_ADD + i];
                mul_a   = st_vj[N_ADD + i];
                mul_b   = st_vk[N_ADD + i];
                mul_imm = st_imm[N_ADD + i];
            end
        end
    end

    // R8: at most one station per unit leaves in a cycle
    p_one_add_dispatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_gnt[N_ADD-1:0]));
    p_one_mul_dispatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_gnt[N_RS-1:N_ADD]));

    // R3: an accepted issue always names a real producer
    p_issue_tag_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |-> (alloc_tag != '0));

endmodule

// File: tb/tb_rs_cluster.sv
`timescale 1ns/1ps
module tb_rs_cluster;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iv = 1'b0, iu = 1'b0;
    logic [3:0]  iop = '0;
    logic [2:0]  idst = '0, isj = '0, isk = '0, paddr = '0;
    logic [15:0] iimm = '0;
    logic        bv = 1'b0;
    logic [3:0]  btag = '0;
    logic [63:0] bdata = '0;

    logic        iss_ready, add_go, mul_go;
    logic [3:0]  add_tag, mul_tag, add_op, mul_op, peek_tag;
    logic [63:0] add_a, add_b, mul_a, mul_b, peek_val;
    logic [15:0] add_imm, mul_imm;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rs_cluster dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iv), .iss_unit(iu), .iss_op(iop), .iss_dst(idst),
        .iss_srcj(isj), .iss_srck(isk), .iss_imm(iimm), .iss_ready(iss_ready),
        .bc_valid(bv), .bc_tag(btag), .bc_data(bdata),
        .add_go(add_go), .add_tag(add_tag), .add_op(add_op),
        .add_a(add_a), .add_b(add_b), .add_imm(add_imm),
        .mul_go(mul_go), .mul_tag(mul_tag), .mul_op(mul_op),
        .mul_a(mul_a), .mul_b(mul_b), .mul_imm(mul_imm),
        .peek_reg(paddr), .peek_val(peek_val), .peek_tag(peek_tag)
    );

    // behavioural reference: station kind 0 free, 1 holding, 2 executing
    int          s_st  [5];
    int          s_qj  [5];
    int          s_qk  [5];
    logic [63:0] s_vj  [5];
    logic [63:0] s_vk  [5];
    logic [3:0]  s_op  [5];
    logic [15:0] s_imm [5];
    logic [63:0] r_val [8];
    int          r_tag [8];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int pick(input int lo, input int hi);
        for (int i = lo; i <= hi; i++)
            if (s_st[i] == 1 && s_qj[i] == 0 && s_qk[i] == 0) return i;
        return -1;
    endfunction

    function automatic int first_free(input logic unit);
        int lo = unit ? 3 : 0;
        int hi = unit ? 4 : 2;
        for (int i = lo; i <= hi; i++)
            if (s_st[i] == 0) return i;
        return -1;
    endfunction

    task automatic compare();
        int ea = pick(0, 2);
        int em = pick(3, 4);
        chk("R2 R9", "iss_ready", 64'(iss_ready), 64'(first_free(iu) >= 0));
        chk("R7 R8", "add_go", 64'(add_go), 64'(ea >= 0));
        if (ea >= 0) begin
            chk("R8", "add_tag", 64'(add_tag), 64'(ea + 1));
            chk("R12", "add_op", 64'(add_op), 64'(s_op[ea]));
            chk("R12", "add_imm", 64'(add_imm), 64'(s_imm[ea]));
            chk("R4 R5 R6", "add_a", add_a, s_vj[ea]);
            chk("R4 R5 R6", "add_b", add_b, s_vk[ea]);
        end
        chk("R7 R8", "mul_go", 64'(mul_go), 64'(em >= 0));
        if (em >= 0) begin
            chk("R8", "mul_tag", 64'(mul_tag), 64'(em + 1));
            chk("R12", "mul_op", 64'(mul_op), 64'(s_op[em]));
            chk("R12", "mul_imm", 64'(mul_imm), 64'(s_imm[em]));
            chk("R4 R5 R6", "mul_a", mul_a, s_vj[em]);
            chk("R4 R5 R6", "mul_b", mul_b, s_vk[em]);
        end
        chk("R3 R11", "peek_tag", 64'(peek_tag), 64'(r_tag[paddr]));
        chk("R10", "peek_val", peek_val, r_val[paddr]);
    endtask

    task automatic update();
        int ai = pick(0, 2);
        int mi = pick(3, 4);
        int ld = iv ? first_free(iu) : -1;
        int tj = r_tag[isj];
        int tk = r_tag[isk];
        logic [63:0] vj = 0, vk = 0;
        int qj = 0, qk = 0;
        if (tj == 0) vj = r_val[isj];
        else if (bv && btag == tj) vj = bdata;
        else qj = tj;
        if (tk == 0) vk = r_val[isk];
        else if (bv && btag == tk) vk = bdata;
        else qk = tk;
        for (int i = 0; i < 5; i++) begin
            if (s_st[i] == 1 && bv && btag != 0) begin
                if (s_qj[i] == btag) begin s_vj[i] = bdata; s_qj[i] = 0; end
                if (s_qk[i] == btag) begin s_vk[i] = bdata; s_qk[i] = 0; end
            end
            if (s_st[i] == 2 && bv && btag == i + 1) s_st[i] = 0;
        end
        if (ai >= 0) s_st[ai] = 2;
        if (mi >= 0) s_st[mi] = 2;
        for (int r = 0; r < 8; r++)
            if (bv && btag != 0 && r_tag[r] == btag && !(ld >= 0 && idst == r)) begin
                r_val[r] = bdata;
                r_tag[r] = 0;
            end
        if (ld >= 0) begin
            s_st[ld] = 1; s_op[ld] = iop; s_imm[ld] = iimm;
            s_vj[ld] = vj; s_vk[ld] = vk; s_qj[ld] = qj; s_qk[ld] = qk;
            r_tag[idst] = ld + 1;
        end
    endtask

    task automatic step();
        #1;
        compare();
        @(posedge clk);
        update();
        @(negedge clk);
        paddr = paddr + 3'd1;
    endtask

    task automatic cyc(input logic v, input logic u, input int op, input int d,
                       input int sj, input int sk, input int imm,
                       input logic b, input int bt, input logic [63:0] bd);
        iv = v; iu = u; iop = 4'(op); idst = 3'(d); isj = 3'(sj); isk = 3'(sk);
        iimm = 16'(imm); bv = b; btag = 4'(bt); bdata = bd;
        step();
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 64'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) begin
            s_st[i] = 0; s_qj[i] = 0; s_qk[i] = 0;
            s_vj[i] = 0; s_vk[i] = 0; s_op[i] = 0; s_imm[i] = 0;
        end
        for (int r = 0; r < 8; r++) begin r_val[r] = 0; r_tag[r] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen at the ports
        for (int r = 0; r < 8; r++) begin
            paddr = 3'(r);
            #0.2;
            chk("R1", "reset peek_tag", 64'(peek_tag), 64'h0);
            chk("R1", "reset peek_val", peek_val, 64'h0);
        end
        iu = 1'b1; #0.2;
        chk("R1", "reset mul ready", 64'(iss_ready), 64'h1);
        iu = 1'b0; #0.2;
        chk("R1", "reset add ready", 64'(iss_ready), 64'h1);
        chk("R1", "reset add_go", 64'(add_go), 64'h0);
        chk("R1", "reset mul_go", 64'(mul_go), 64'h0);
        idle();

        // R4: values straight from registers, dispatch next cycle
        cyc(1, 0, 3, 1, 0, 0, 5, 0, 0, 64'h0);
        idle();
        // R10: write r1 through tag 1; issue multiply into r2 (tag 4)
        cyc(1, 1, 2, 2, 0, 0, 7, 1, 1, 64'h1111_0000_0000_1111);
        idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 4, 64'h2222_0000_0000_2222);
        // R4: both sources present with nonzero values
        cyc(1, 0, 1, 3, 1, 2, 9, 0, 0, 64'h0);
        // R6: multiply waits on tag 1 for r3
        cyc(1, 1, 4, 4, 3, 1, 11, 0, 0, 64'h0);
        idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 64'h3333_0000_0000_3333);
        idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 4, 64'h4444_0000_0000_4444);
        // R5: same-cycle broadcast captured at issue
        cyc(1, 0, 5, 6, 1, 1, 13, 0, 0, 64'h0);
        idle();
        cyc(1, 1, 6, 7, 6, 6, 15, 1, 1, 64'h6666_0000_0000_6666);
        idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 4, 64'h7777_0000_0000_7777);
        // R11: issue to r5 while its producer broadcasts
        cyc(1, 0, 7, 5, 1, 2, 17, 0, 0, 64'h0);
        idle();
        cyc(1, 0, 8, 5, 1, 1, 19, 1, 1, 64'h5555_0000_0000_5555);
        // R2: fill adder stations with waiters on r5 (tag 2), then try one more
        cyc(1, 0, 9, 6, 5, 1, 21, 0, 0, 64'h0);
        cyc(1, 0, 10, 0, 5, 5, 23, 0, 0, 64'h0);
        cyc(1, 0, 11, 3, 3, 3, 25, 0, 0, 64'h0);
        // R8: two waiters wake together, lower number goes first
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2, 64'h8888_0000_0000_8888);
        repeat (4) idle();
        // R9: release everything that executes
        for (int t = 1; t <= 5; t++) cyc(0, 0, 0, 0, 0, 0, 0, 1, t, 64'(t) * 64'h0101);
        // R6: bus with tag 0 or valid low is ignored
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 64'hdead);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 3, 64'hbeef);

        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int unsigned a = $urandom;
            int unsigned b = $urandom;
            cyc(a[1:0] != 2'd0, a[2], int'(a[6:3]), int'(a[9:7]), int'(a[12:10]),
                int'(a[15:13]), int'(a[31:16]), b[0] | b[1],
                (b[4:2] == 3'd7) ? 0 : int'(b[4:2] % 3'd5) + 1, {b, a});
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule